// File: doc/BRIEF.md
# Byte-Serial Stuffing Store Unit

This unit drains a packed bit-buffer word into byte-addressed memory. A start strobe delivers a 32-bit word and a count of how many of its bytes are valid. The unit then writes those bytes one at a time, most significant byte first, through a byte-wide write port that uses a request/acknowledge handshake. Each write goes to the address held in the unit's own pointer register. The pointer steps forward by one on every acknowledged byte. Because the destination is only known to be byte aligned, the unit never issues a wider access.

Any data byte equal to 0xFF is followed at once by an inserted 0x00 byte. This keeps the byte stream free of false marker codes. A store therefore takes between one and eight byte writes, and each write lasts as long as memory takes to acknowledge it. The total time is not fixed. While the sequence runs, the unit holds a stall output high so that the processor fetches no new instructions. Stall falls to signal that the store has finished.

The pointer is exposed as an output so that it can be read like a special-purpose register. It can be loaded whenever the unit is idle.

Top module: `stuff_store_unit`

## Requirements
- R1: A synchronous reset, rst high at a clock edge, leaves stall_o and mem_req_o low and addr_o at zero after that edge.
- R2: A start_i pulse while idle with count_i from 1 to 4 raises mem_req_o and stall_o in the next cycle. The valid bytes of data_i are then written most significant first, i.e. data_i[31:24] first, and only count_i bytes are written.
- R3: Every written data byte equal to 8'hFF is followed directly by a write of 8'h00.
- R4: While mem_req_o is high and mem_ack_i is low, mem_req_o, mem_addr_o and mem_data_o hold their values into the next cycle.
- R5: addr_o increases by exactly one after each clock edge at which mem_req_o and mem_ack_i are both high, stuffed 8'h00 bytes included, and mem_addr_o equals addr_o.
- R6: stall_o is high for the whole store sequence and falls in the cycle after the acknowledge of the last byte.
- R7: A start_i pulse received while a store is in progress has no effect on the bytes written or on the final address.
- R8: A start with count_i equal to 0 is ignored (stall_o stays low). A count_i above 4 is treated as 4.
- R9: addr_wr_i loads addr_wdata_i into the pointer at the next edge when the unit is idle. A load request while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start a store of data_i |
| data_i | input | 32 | Packed bit-buffer word |
| count_i | input | 3 | Number of valid bytes, MSB first |
| addr_wr_i | input | 1 | Load request for the address pointer |
| addr_wdata_i | input | 32 | Value to load into the pointer |
| addr_o | output | 32 | Current address pointer |
| mem_req_o | output | 1 | Byte write request |
| mem_addr_o | output | 32 | Byte write address |
| mem_data_o | output | 8 | Byte write data |
| mem_ack_i | input | 1 | Memory acknowledge of the current write |
| stall_o | output | 1 | Processor stall, high while storing |

## Verification
The assertions cover the rules that hold on every cycle. They check that a pending request stays stable until it is acknowledged, that an acknowledged 0xFF byte is always followed by a 0x00 byte, that the pointer steps by one per acknowledge, that zero-count starts and busy-time loads change nothing, and what reset leaves behind.

Some properties only the bench's scenarios can show, because they concern whole byte sequences. These are the order and number of bytes written for each count, the stuffing of adjacent 0xFF runs, the exact cycle at which stall falls under different acknowledge rhythms, and the final address reached after a start or a load is refused while busy.

// File: rtl/ssu_pkg.sv
package ssu_pkg;
    localparam int unsigned BYTE_W        = 8;
    localparam logic [7:0]  STUFF_TRIGGER = 8'hFF;
    localparam logic [7:0]  STUFF_FILL    = 8'h00;
endpackage

// File: rtl/ssu_seq.sv
// Byte sequencer: walks the valid bytes MSB first and inserts the fill byte
// after every trigger byte.
module ssu_seq #(
    parameter int unsigned WORD_BYTES = 4,
    parameter int unsigned CNT_W      = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        start_i,
    input  logic [WORD_BYTES*8-1:0]     word_i,
    input  logic [CNT_W-1:0]            count_i,
    input  logic                        ack_i,
    output logic                        busy_o,
    output logic [7:0]                  byte_o
);
    import ssu_pkg::*;

    localparam int unsigned WORD_W = WORD_BYTES * BYTE_W;
    localparam int unsigned REM_W  = $clog2(WORD_BYTES + 1);

    typedef struct packed {
        logic              busy;
        logic              stuff;
        logic [REM_W-1:0]  rem;
        logic [WORD_W-1:0] word;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [7:0] head_byte;

    assign head_byte = seq_q.word[WORD_W-1 -: BYTE_W];

    always_comb begin
        seq_d = seq_q;
        if (!seq_q.busy) begin
            if (start_i && (count_i != '0)) begin
                seq_d.busy  = 1'b1;
                seq_d.stuff = 1'b0;
                seq_d.word  = word_i;
                if (int'(count_i) > int'(WORD_BYTES))
                    seq_d.rem = REM_W'(WORD_BYTES);
                else
                    seq_d.rem = REM_W'(count_i);
            end
        end else if (ack_i) begin
            if (seq_q.stuff) begin
                seq_d.stuff = 1'b0;
                seq_d.busy  = (seq_q.rem != '0);
            end else begin
                seq_d.word  = seq_q.word << BYTE_W;
                seq_d.rem   = seq_q.rem - REM_W'(1);
                seq_d.stuff = (head_byte == STUFF_TRIGGER);
                seq_d.busy  = (seq_q.rem != REM_W'(1)) || (head_byte == STUFF_TRIGGER);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) seq_q <= '0;
        else     seq_q <= seq_d;
    end

    assign busy_o = seq_q.busy;
    assign byte_o = seq_q.stuff ? STUFF_FILL : head_byte;

    // R8: a zero-count start leaves the unit idle
    a_r8_zero_count_idle: assert property (@(posedge clk) disable iff (rst)
        (!seq_q.busy && start_i && count_i == '0) |=> !seq_q.busy);

    // R7: a start during a store does not disturb the word being drained
    a_r7_busy_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (seq_q.busy && start_i && !ack_i) |=> ($stable(seq_q.word) && $stable(seq_q.rem)));

    // R4: no progress without an acknowledge
    a_r4_no_ack_no_step: assert property (@(posedge clk) disable iff (rst)
        (seq_q.busy && !ack_i) |=> ($stable(seq_q.stuff) && seq_q.busy));
endmodule

// File: rtl/ssu_addr.sv
// Write address pointer: loadable when idle, steps on each accepted byte.
module ssu_addr #(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              busy_i,
    input  logic              step_i,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_val_i,
    output logic [ADDR_W-1:0] addr_o
);
    logic [ADDR_W-1:0] addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (busy_i) begin
            if (step_i) addr_d = addr_q + ADDR_W'(1);
        end else if (load_i) begin
            addr_d = load_val_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) addr_q <= '0;
        else     addr_q <= addr_d;
    end

    assign addr_o = addr_q;

    // R5: one step per accepted byte
    a_r5_step_by_one: assert property (@(posedge clk) disable iff (rst)
        (busy_i && step_i) |=> (addr_q == $past(addr_q) + ADDR_W'(1)));

    // R9: loads are refused during a store
    a_r9_load_blocked_busy: assert property (@(posedge clk) disable iff (rst)
        (busy_i && !step_i) |=> $stable(addr_q));
endmodule

// File: rtl/stuff_store_unit.sv
module stuff_store_unit #(
    parameter int unsigned WORD_BYTES = 4,
    parameter int unsigned CNT_W      = 3,
    parameter int unsigned ADDR_W     = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start_i,
    input  logic [WORD_BYTES*8-1:0] data_i,
    input  logic [CNT_W-1:0]        count_i,
    input  logic                    addr_wr_i,
    input  logic [ADDR_W-1:0]       addr_wdata_i,
    output logic [ADDR_W-1:0]       addr_o,
    output logic                    mem_req_o,
    output logic [ADDR_W-1:0]       mem_addr_o,
    output logic [7:0]              mem_data_o,
    input  logic                    mem_ack_i,
    output logic                    stall_o
);
    import ssu_pkg::*;

    logic       busy;
    logic [7:0] cur_byte;
    logic [ADDR_W-1:0] ptr;

    ssu_seq #(.WORD_BYTES(WORD_BYTES), .CNT_W(CNT_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .word_i  (data_i),
        .count_i (count_i),
        .ack_i   (mem_ack_i),
        .busy_o  (busy),
        .byte_o  (cur_byte)
    );

    ssu_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk        (clk),
        .rst        (rst),
        .busy_i     (busy),
        .step_i     (mem_ack_i),
        .load_i     (addr_wr_i),
        .load_val_i (addr_wdata_i),
        .addr_o     (ptr)
    );

    assign addr_o     = ptr;
    assign mem_addr_o = ptr;
    assign mem_data_o = cur_byte;
    assign mem_req_o  = busy;
    assign stall_o    = busy;

    // R1: reset leaves the unit idle at address zero
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!stall_o && !mem_req_o && addr_o == '0));

    // R2: an accepted start raises request and stall next cycle
    a_r2_start_raises: assert property (@(posedge clk) disable iff (rst)
        (!stall_o && start_i && count_i != '0) |=> (stall_o && mem_req_o));

    // R3: an accepted trigger byte is followed by the fill byte
    a_r3_fill_follows: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && mem_ack_i && mem_data_o == STUFF_TRIGGER) |=>
        (mem_req_o && mem_data_o == STUFF_FILL));

    // R4: a pending write holds its request, address and data
    a_r4_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && !mem_ack_i) |=>
        (mem_req_o && $stable(mem_addr_o) && $stable(mem_data_o)));
endmodule

// File: tb/tb_stuff_store_unit.sv
module tb_stuff_store_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [31:0] data_i = '0;
    logic [2:0]  count_i = '0;
    logic        addr_wr_i = 1'b0;
    logic [31:0] addr_wdata_i = '0;
    logic [31:0] addr_o;
    logic        mem_req_o;
    logic [31:0] mem_addr_o;
    logic [7:0]  mem_data_o;
    logic        mem_ack_i = 1'b0;
    logic        stall_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int ack_mode = 0;
    bit done = 0;

    logic [7:0]  exp_q[$];
    logic [31:0] m_addr = '0;

    always #2.5 clk = ~clk;

    stuff_store_unit dut (
        .clk(clk), .rst(rst), .start_i(start_i), .data_i(data_i),
        .count_i(count_i), .addr_wr_i(addr_wr_i), .addr_wdata_i(addr_wdata_i),
        .addr_o(addr_o), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
        .mem_data_o(mem_data_o), .mem_ack_i(mem_ack_i), .stall_o(stall_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Reference model: a queue of bytes still to be written and a pointer
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            exp_q.delete();
            m_addr = '0;
        end else if (exp_q.size() != 0) begin
            if (mem_ack_i) begin
                void'(exp_q.pop_front());
                m_addr = m_addr + 1;
            end
        end else begin
            if (addr_wr_i) m_addr = addr_wdata_i;
            if (start_i && count_i != 0) begin
                int n;
                n = (count_i > 4) ? 4 : int'(count_i);
                for (int i = 0; i < n; i++) begin
                    logic [7:0] b;
                    b = data_i[31-8*i -: 8];
                    exp_q.push_back(b);
                    if (b == 8'hFF) exp_q.push_back(8'h00);
                end
            end
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R6 stall", {31'b0, stall_o}, {31'b0, exp_q.size() != 0});
            check("R2 req", {31'b0, mem_req_o}, {31'b0, exp_q.size() != 0});
            check("R5 addr", addr_o, m_addr);
            if (exp_q.size() != 0) begin
                check("R4 write addr", mem_addr_o, m_addr);
                check("R3 data", {24'b0, mem_data_o}, {24'b0, exp_q[0]});
            end
        end
    end

    // Memory acknowledge rhythm
    initial begin
        forever begin
            @(negedge clk);
            case (ack_mode)
                0: mem_ack_i = 1'b1;
                1: mem_ack_i = (cyc % 3 == 2);
                default: mem_ack_i = (cyc % 2 == 0);
            endcase
        end
    end

    task automatic store(input logic [31:0] d, input logic [2:0] n);
        @(negedge clk);
        start_i = 1'b1; data_i = d; count_i = n;
        @(negedge clk);
        start_i = 1'b0;
        while (stall_o) @(negedge clk);
    endtask

    task automatic load(input logic [31:0] a);
        @(negedge clk);
        addr_wr_i = 1'b1; addr_wdata_i = a;
        @(negedge clk);
        addr_wr_i = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset stall", {31'b0, stall_o}, 32'd0);
        check("R1 reset req", {31'b0, mem_req_o}, 32'd0);
        check("R1 reset addr", addr_o, 32'd0);

        load(32'h0000_1000);
        check("R9 idle load", addr_o, 32'h0000_1000);

        ack_mode = 0;
        store(32'h1234_5678, 3'd4);
        check("R2 four plain bytes", addr_o, 32'h0000_1004);

        ack_mode = 1;
        store(32'hFF00_FFAA, 3'd4);
        check("R3 mixed stuffing", addr_o, 32'h0000_100A);

        ack_mode = 2;
        store(32'hFFFF_FFFF, 3'd4);
        check("R5 all trigger bytes", addr_o, 32'h0000_1012);

        ack_mode = 0;
        store(32'hFF12_3456, 3'd1);
        check("R2 single byte count", addr_o, 32'h0000_1014);

        @(negedge clk);
        start_i = 1'b1; data_i = 32'hFFFF_FFFF; count_i = 3'd0;
        @(negedge clk);
        start_i = 1'b0;
        check("R8 zero count stall", {31'b0, stall_o}, 32'd0);
        check("R8 zero count addr", addr_o, 32'h0000_1014);

        store(32'h0102_0304, 3'd7);
        check("R8 count above four", addr_o, 32'h0000_1018);

        // start and address load while busy are both refused
        ack_mode = 1;
        @(negedge clk);
        start_i = 1'b1; data_i = 32'hAABB_CCDD; count_i = 3'd2;
        @(negedge clk);
        data_i = 32'hFFFF_FFFF; count_i = 3'd4;
        addr_wr_i = 1'b1; addr_wdata_i = 32'h0000_5000;
        @(negedge clk);
        start_i = 1'b0; addr_wr_i = 1'b0;
        while (stall_o) @(negedge clk);
        check("R7 busy start ignored", addr_o, 32'h0000_101A);
        check("R9 busy load ignored", addr_o, 32'h0000_101A);

        load(32'h0000_2FFF);
        ack_mode = 2;
        store(32'hFFFF_0012, 3'd3);
        check("R6 stall low after run", {31'b0, stall_o}, 32'd0);
        check("R5 carry across boundary", addr_o, 32'h0000_3004);

        repeat (3) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end
endmodule